// File: doc/BRIEF.md
# Cascadable Serial Configuration Reader

This block is the read side of a bit-serial memory that an FPGA loads its configuration from in master serial mode. The FPGA supplies the clock. It also drives a chip enable and one combined pin that acts as a counter clear at one level and as an output enable at the other. On each rising clock edge in read mode the block shifts out the next bit of a stored array. The output is a data value plus a drive-enable, so the surrounding logic builds the tri-state line from them.

Several blocks can share one data line as a chain. Each block's chain-enable output feeds the chip enable of the next block. When a block has sent its last bit it stops driving the line and pulls its chain-enable output low, so the next block takes over on the following clock. A configuration input selects which level of the combined pin means clear. A serial-enable input set low puts the block into programming mode, where the read path is switched off. A ready flag stays low for a set number of cycles after reset. The array is loaded through a simple test write port.

Top module: `cfg_serial_reader`

## Requirements
- R1: While `rst_n` is low, `ready` and `dout_oe` are 0 and `ceo_n` is 1. `ready` rises exactly POR_CYCLES+2 rising clock edges after `rst_n` is released (two of those cycles are the reset synchronizer), and it stays high after that. While `ready` is low, `dout_oe` is 0 and `ceo_n` is 1.
- R2: With `ser_en` high and `ready` high, holding the combined pin at its clear level for one clock edge sets the bit position back to 0 and clears the end-of-array state. During that cycle `dout_oe` is 0, whatever the value of `ce_n`.
- R3: With `ce_n` low and the combined pin at its enable level, `dout_oe` is 1 and `dout` equals array bit N, where N is the current bit position. Each rising clock edge advances N by one. Bit 0 is on `dout` in the first enabled cycle after a clear.
- R4: When `ce_n` is high, the bit position holds its value and `dout_oe` is 0, whatever the level of the combined pin.
- R5: After bit DEPTH-1 has been clocked out, `dout_oe` stays 0 and the bit position stops advancing. From then on `ceo_n` is low whenever `ce_n` is low and the combined pin is at its enable level.
- R6: Once the end of the array is reached, `ceo_n` equals `ce_n` for as long as the pin is at its enable level. A clear puts `ceo_n` back to 1, and it stays 1 until the whole array has been read again.
- R7: With `pol_inv`=0, the pin low means clear and the pin high means enable. With `pol_inv`=1, the two levels are swapped.
- R8: While `ser_en` is low, `dout_oe` is 0 and `ceo_n` is 1. Changes on `ce_n` and on the combined pin have no effect, and the bit position is kept. The read resumes at the same bit once `ser_en` returns high.
- R9: `tst_we` high at a rising edge writes `tst_bit` into array index `tst_addr`. Index 0 is the first bit shifted out. `dout` is 0 whenever `dout_oe` is 0.
- R10: Two blocks chained through `ceo_n` to `ce_n` produce the first block's DEPTH bits followed directly by the second block's bits. There is no gap cycle and no cycle in which both blocks drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock. State changes on its rising edge. |
| rst_n | input | 1 | Power-on reset, active low. It asserts asynchronously and is released synchronously. |
| ce_n | input | 1 | Chip enable, active low. |
| rst_oe | input | 1 | Combined pin: clear at one level, output enable at the other. |
| ser_en | input | 1 | Read mode when high, programming mode when low. |
| pol_inv | input | 1 | Polarity of the combined pin. 0 means low clears; 1 means high clears. |
| tst_we | input | 1 | Write strobe of the test write port. |
| tst_addr | input | AW | Array index for the test write. |
| tst_bit | input | 1 | Bit value for the test write. |
| dout | output | 1 | Serial data value. |
| dout_oe | output | 1 | Drive enable for the data line. |
| ceo_n | output | 1 | Chain-enable output, active low, for the next block. |
| ready | output | 1 | Power-on cycle complete. |

## Verification
The bench goes after the handoff between two chained blocks. If the end-of-array detection were off by one, a bit would be lost or repeated, or both blocks would drive the line in the same cycle. It raises chip enable in the middle of the second block's stream. A `ceo_n` latched low at the end of the array, instead of following `ce_n`, would let the second block keep shifting. A clear with chip enable high shows whether reset depends on enable. Toggling the pin during programming mode shows whether the pin is ignored there. Running with inverted polarity catches a hard-wired clear level.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
  // Read-path operating mode, resolved once per cycle from the pins.
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,  // programming mode or still in power-on cycle
    MODE_CLEAR = 2'd1,  // combined pin at its clear level
    MODE_HOLD  = 2'd2,  // standby or array exhausted
    MODE_SHIFT = 2'd3   // driving and advancing
  } rd_mode_e;
endpackage

// File: rtl/cfg_rd_por.sv
module cfg_rd_por #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n,
  output logic ready
);
  localparam int PW = $clog2(POR_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!rdy_q) begin
      cnt_d = cnt_q + PW'(1);
      if (cnt_q == PW'(POR_CYCLES - 1)) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end
  assign ready = rdy_q;

  // R1: ready never drops once the power-on cycle has finished
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |=> ready);
  // R1: ready rises only after the full cycle count has elapsed
  a_r1_ready_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ready) |-> (cnt_q == PW'(POR_CYCLES)));
endmodule

// File: rtl/cfg_rd_decode.sv
module cfg_rd_decode
  import cfg_rd_pkg::*;
(
  input  logic     ser_en,
  input  logic     ready,
  input  logic     ce_n,
  input  logic     rst_oe,
  input  logic     pol_inv,
  input  logic     done,
  output rd_mode_e mode,
  output logic     ceo_n
);
  logic read_on;
  logic oe_lvl;

  assign read_on = ser_en & ready;
  assign oe_lvl  = rst_oe ^ pol_inv;

  always_comb begin
    if (!read_on)         mode = MODE_OFF;
    else if (!oe_lvl)     mode = MODE_CLEAR;
    else if (ce_n | done) mode = MODE_HOLD;
    else                  mode = MODE_SHIFT;
  end

  assign ceo_n = ~(read_on & oe_lvl & ~ce_n & done);
endmodule

// File: rtl/cfg_rd_counter.sv
module cfg_rd_counter
  import cfg_rd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_mode_e      mode,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    case (mode)
      MODE_CLEAR: begin
        addr_d = '0;
        done_d = 1'b0;
      end
      MODE_SHIFT: begin
        if (addr_q == LAST) done_d = 1'b1;
        else                addr_d = addr_q + AW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr = addr_q;
  assign done = done_q;

  a_r2_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |=> (addr == '0 && !done));
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT && addr != LAST) |=> (addr == $past(addr) + AW'(1) && !done));
  a_r5_end_reached: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT && addr == LAST) |=> (done && addr == LAST));
  a_r4_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD || mode == MODE_OFF) |=> ($stable(addr) && $stable(done)));
endmodule

// File: rtl/cfg_rd_array.sv
module cfg_rd_array #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic [DEPTH-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic hit;
    assign hit = we & (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) cells[g] <= wbit;
    end
  end

  assign rbit = cells[raddr];
endmodule

// File: rtl/cfg_serial_reader.sv
module cfg_serial_reader
  import cfg_rd_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int POR_CYCLES = 16,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          ser_en,
  input  logic          pol_inv,
  input  logic          tst_we,
  input  logic [AW-1:0] tst_addr,
  input  logic          tst_bit,
  output logic          dout,
  output logic          dout_oe,
  output logic          ceo_n
  ,output logic          ready
);
  logic          rst_sync_n;
  logic          done;
  logic [AW-1:0] addr;
  logic          rbit;
  rd_mode_e      mode;

  cfg_rd_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n),
    .ready      (ready)
  );

  cfg_rd_decode u_decode (
    .ser_en  (ser_en),
    .ready   (ready),
    .ce_n    (ce_n),
    .rst_oe  (rst_oe),
    .pol_inv (pol_inv),
    .done    (done),
    .mode    (mode),
    .ceo_n   (ceo_n)
  );

  cfg_rd_counter #(.DEPTH(DEPTH), .AW(AW)) u_counter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .mode  (mode),
    .addr  (addr),
    .done  (done)
  );

  cfg_rd_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk   (clk),
    .we    (tst_we),
    .waddr (tst_addr),
    .wbit  (tst_bit),
    .raddr (addr),
    .rbit  (rbit)
  );

  assign dout_oe = (mode == MODE_SHIFT);
  assign dout    = rbit & dout_oe;

  a_r1_quiet_before_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ready |-> (!dout_oe && ceo_n));
  a_r2_quiet_in_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ser_en && ready && (rst_oe == pol_inv)) |-> !dout_oe);
  a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_n |-> !dout_oe);
  a_r5_release_at_end: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !dout_oe);
  a_r6_ceo_needs_ce: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ceo_n |-> (!ce_n && done));
  a_r8_prog_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ser_en |-> (!dout_oe && ceo_n));
endmodule

// File: tb/test_cfg_serial_reader.sv
module test_cfg_serial_reader;
  localparam int DEPTH = 32;
  localparam int POR   = 6;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, ce_n, rst_oe, ser_en, pol_inv;
  logic          we_a, we_b, wbit_a, wbit_b;
  logic [AW-1:0] waddr;
  logic          d_a, oe_a, ceo_a, rdy_a;
  logic          d_b, oe_b, ceo_b, rdy_b;

  cfg_serial_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR)) i_cfg_serial_reader (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(rst_oe), .ser_en(ser_en),
    .pol_inv(pol_inv), .tst_we(we_a), .tst_addr(waddr), .tst_bit(wbit_a),
    .dout(d_a), .dout_oe(oe_a), .ceo_n(ceo_a), .ready(rdy_a));

  cfg_serial_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR)) i_cfg_serial_reader_b (
    .clk(clk), .rst_n(rst_n), .ce_n(ceo_a), .rst_oe(rst_oe), .ser_en(ser_en),
    .pol_inv(pol_inv), .tst_we(we_b), .tst_addr(waddr), .tst_bit(wbit_b),
    .dout(d_b), .dout_oe(oe_b), .ceo_n(ceo_b), .ready(rdy_b));

  typedef struct {
    string tag;
    logic  oa, da, ca, ob, db, cb;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;

  bit mem_a[DEPTH];
  bit mem_b[DEPTH];
  int cnt_a, cnt_b;
  bit done_a, done_b;

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // Driver: applies one cycle of pins, pushes the expected outputs, advances the model
  task automatic step(input bit ce, input bit pin, input bit ser, input bit pol, input string tag);
    item_t it;
    bit oel, drva, drvb;
    @(negedge clk); #1;
    ce_n = ce; rst_oe = pin; ser_en = ser; pol_inv = pol;
    oel  = pin ^ pol;
    drva = ser && !ce && oel && !done_a;
    it.oa = drva;
    it.da = drva ? mem_a[cnt_a] : 1'b0;
    it.ca = !(ser && oel && !ce && done_a);
    drvb = ser && !it.ca && oel && !done_b;
    it.ob = drvb;
    it.db = drvb ? mem_b[cnt_b] : 1'b0;
    it.cb = !(ser && oel && !it.ca && done_b);
    it.tag = tag;
    q.push_back(it);
    if (ser && !oel) begin
      cnt_a = 0; done_a = 0; cnt_b = 0; done_b = 0;
    end else begin
      if (drva) begin if (cnt_a == DEPTH-1) done_a = 1; else cnt_a++; end
      if (drvb) begin if (cnt_b == DEPTH-1) done_b = 1; else cnt_b++; end
    end
  endtask

  // Monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({oe_a, d_a, ceo_a, oe_b, d_b, ceo_b} === {it.oa, it.da, it.ca, it.ob, it.db, it.cb}
              && !(oe_a && oe_b),
              $sformatf("%s: actual oeA/dA/ceoA/oeB/dB/ceoB=%b%b%b%b%b%b expected %b%b%b%b%b%b",
                        it.tag, oe_a, d_a, ceo_a, oe_b, d_b, ceo_b,
                        it.oa, it.da, it.ca, it.ob, it.db, it.cb));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seen;
    rst_n = 0; ce_n = 1; rst_oe = 0; ser_en = 1; pol_inv = 0;
    we_a = 0; we_b = 0; wbit_a = 0; wbit_b = 0; waddr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mem_a[i] = ((i * 13 + 5) >> 2) & 1;
      mem_b[i] = (((i * 11 + 1) >> 1) ^ i) & 1;
    end
    cnt_a = 0; cnt_b = 0; done_a = 0; done_b = 0;

    repeat (3) @(negedge clk);
    #1;
    check(!rdy_a && !oe_a && ceo_a && !rdy_b,
          $sformatf("R1 reset state: actual rdy=%b oe=%b ceo=%b expected 0 0 1", rdy_a, oe_a, ceo_a));

    @(negedge clk); #1; rst_n = 1;
    seen = 0;
    for (int k = 1; k <= POR + 10; k++) begin
      @(posedge clk); #1;
      if (seen == 0 && rdy_a) seen = k;
      if (seen == 0) check(!oe_a && ceo_a, "R1 quiet while not ready: actual driving, expected idle");
    end
    check(seen == POR + 2, $sformatf("R1 ready edge: actual %0d expected %0d", seen, POR + 2));
    check(rdy_b == 1'b1, $sformatf("R1 second block ready: actual %b expected 1", rdy_b));

    // R9 load both arrays through the test port (pin at clear level)
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); #1;
      we_a = 1; we_b = 1; waddr = AW'(i); wbit_a = mem_a[i]; wbit_b = mem_b[i];
    end
    @(negedge clk); #1; we_a = 0; we_b = 0;

    step(0, 0, 1, 0, "R2 clear with ce low");
    step(0, 0, 1, 0, "R2 clear with ce low");
    for (int i = 0; i < 10; i++) step(0, 1, 1, 0, "R3 R9 stream A");
    for (int i = 0; i < 3; i++)  step(1, 1, 1, 0, "R4 standby freezes");
    for (int i = 0; i < DEPTH - 10; i++) step(0, 1, 1, 0, "R3 R9 stream A rest");
    for (int i = 0; i < 5; i++)  step(0, 1, 1, 0, "R5 R10 handoff to B");
    step(1, 1, 1, 0, "R6 ceo follows ce high");
    step(1, 1, 1, 0, "R6 ceo follows ce high");
    for (int i = 0; i < DEPTH - 5; i++) step(0, 1, 1, 0, "R10 stream B");
    step(0, 1, 1, 0, "R5 both ended");
    step(0, 1, 1, 0, "R5 both ended");
    step(0, 0, 1, 0, "R6 clear raises ceo");
    step(0, 0, 1, 0, "R6 clear raises ceo");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, "R3 first bit after clear");
    step(1, 0, 1, 0, "R2 clear with ce high");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, "R2 restart at bit 0");
    step(0, 1, 0, 0, "R8 programming mode quiet");
    step(1, 1, 0, 0, "R8 ce ignored");
    step(0, 0, 0, 0, "R8 pin ignored");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, "R8 resume same bit");
    step(0, 1, 1, 1, "R7 inverted clear");
    step(0, 1, 1, 1, "R7 inverted clear");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, "R7 inverted stream");
    step(0, 1, 1, 1, "R7 inverted clear again");
    step(0, 0, 1, 1, "R7 inverted restart");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule